// File: doc/BRIEF.md
# Programmable Watchdog with Reset Steering

The block is a single-register watchdog timer. Software writes one 8-bit control byte that sets the timeout and chooses what happens when the timeout runs out. The timeout is a 5-bit multiplier scaled by a power of four. It is counted in ticks of an external 16 Hz enable, so one tick is one sixteenth of a second. Writing the byte or reading it back restarts the countdown. A healthy system therefore services the watchdog by reading the register periodically.

When the count runs out, the block records the event in a fired flag. It then does one of two things, chosen by the steering bit. It either pulses an interrupt for one cycle, or it requests a system reset. A reset request also wipes the control byte and strobes a clear line toward a bit in a neighbouring control register. The countdown is one-shot: after an expiry nothing further happens until software restarts it.

Top module: `wdog_steer`

## Requirements
- R1: After synchronous reset, the stored control byte reads 0x00 and the fired flag, interrupt, reset request and clear strobe are all low.
- R2: Control byte bits [1:0] hold the resolution R and bits [6:2] hold the multiplier M. The timeout is L = M × 4^R ticks. The expiry outputs assert on the clock edge that samples the L-th tick after a restart.
- R3: When M is zero (this covers the byte 0x00), the watchdog is stopped and no expiry ever occurs, whatever the ticks do.
- R4: A write stores the byte, so cfg_rdata shows it one cycle later. The write also restarts the countdown with the interval of the new byte.
- R5: A read restarts the countdown with the interval of the stored byte and leaves the stored byte unchanged.
- R6: Every restart clears the fired flag, and every expiry sets it.
- R7: With bit 7 of the control byte clear, an expiry raises wd_irq for exactly one cycle and leaves wd_rst_req and ctl_bit_clr low.
- R8: With bit 7 set, an expiry does four things in the same cycle. It pulses wd_rst_req and ctl_bit_clr for exactly one cycle, clears the stored byte to 0x00, and leaves wd_irq low.
- R9: After an expiry, no further expiry occurs until the next restart.
- R10: If a restart and a tick arrive in the same cycle, the restart wins. No expiry occurs and the full new interval is loaded.
- R11: The count advances only on cycles where tick16_en is high. Idle cycles between ticks do not shorten the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16_en | input | 1 | One-cycle enable at 16 Hz |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte to store |
| cfg_rd | input | 1 | Read strobe; services (restarts) the watchdog |
| cfg_rdata | output | 8 | Stored control byte |
| wd_irq | output | 1 | One-cycle interrupt pulse on expiry |
| wd_rst_req | output | 1 | One-cycle reset request on steered expiry |
| wd_fired | output | 1 | Fired flag: set by expiry, cleared by restart |
| ctl_bit_clr | output | 1 | One-cycle clear strobe for an external control bit |

## Verification
The hardest case to reach is a service read that coincides with the final tick of a countdown. To reach it, the stimulus loads a one-tick interval, then raises the read strobe and the tick enable in the same cycle. It confirms that no pulse appears and that one further tick is still needed. The longest interval (M = 31, R = 3, 1984 ticks) is also driven in full, so that the top resolution and the counter width are covered. Every expected pulse is queued before the tick that should cause it, and any pulse that was not queued is reported.

// File: rtl/wdog_pkg.sv
// Shared widths and the control-byte layout for the watchdog.
// Assumes the byte is steering bit, multiplier, resolution from MSB to LSB.
package wdog_pkg;
    localparam int MULT_W  = 5;
    localparam int RES_W   = 2;
    localparam int REG_W   = 1 + MULT_W + RES_W;
    localparam int NUM_RES = 1 << RES_W;
    localparam int CNT_W   = MULT_W + 2 * (NUM_RES - 1);

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wdog_cfg_t;
endpackage

// File: rtl/wdog_cfg_reg.sv
// Holds the control byte. A write stores new data; a steered expiry wipes it.
// Assumes a write and a steered expiry never land in the same cycle
// (expiry is suppressed by any restart).
module wdog_cfg_reg
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  wdog_cfg_t wdata_i,
    input  logic      wipe_i,
    output wdog_cfg_t cfg_o
);
    // Control byte storage with write and wipe.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_o <= '0;
        else if (wr_i)    cfg_o <= wdata_i;
        else if (wipe_i)  cfg_o <= '0;
    end
endmodule

// File: rtl/wdog_interval.sv
// Turns a control byte into a tick count: multiplier shifted by twice the
// resolution. Purely combinational; one candidate per resolution value.
module wdog_interval
    import wdog_pkg::*;
(
    input  wdog_cfg_t          cfg_i,
    output logic [CNT_W-1:0]   load_o
);
    logic [CNT_W-1:0] cand [NUM_RES];

    for (genvar r = 0; r < NUM_RES; r++) begin : g_res
        // Candidate interval for resolution r.
        assign cand[r] = CNT_W'(cfg_i.mult) << (2 * r);
    end

    // Pick the candidate named by the resolution field.
    assign load_o = cand[cfg_i.res];
endmodule

// File: rtl/wdog_counter.sv
// One-shot down counter. A restart loads the interval and arms the counter
// if the interval is nonzero. Each tick decrements it, and the tick that
// takes the count from one to zero is the expiry. A restart beats a tick.
module wdog_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             tick_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] count_q;
    logic             running_q;

    // Load on restart, count down on ticks, disarm after the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            running_q <= 1'b0;
        end else if (restart_i) begin
            count_q   <= load_i;
            running_q <= (load_i != '0);
        end else if (running_q && tick_i) begin
            count_q <= count_q - 1'b1;
            if (count_q == CNT_W'(1)) running_q <= 1'b0;
        end
    end

    // Expiry event: final tick of an armed count with no competing restart.
    assign expire_o = running_q & tick_i & ~restart_i & (count_q == CNT_W'(1));
endmodule

// File: rtl/wdog_action.sv
// Registers the expiry actions: fired flag, interrupt or reset pulse, and
// the external clear strobe. The steering bit is sampled at expiry.
module wdog_action (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic expire_i,
    input  logic steer_i,
    output logic irq_o,
    output logic rst_req_o,
    output logic clr_o,
    output logic fired_o
);
    // One-cycle pulses steered by the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            rst_req_o <= 1'b0;
            clr_o     <= 1'b0;
        end else begin
            irq_o     <= expire_i & ~steer_i;
            rst_req_o <= expire_i & steer_i;
            clr_o     <= expire_i & steer_i;
        end
    end

    // Fired flag: cleared by restart, set by expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)          fired_o <= 1'b0;
        else if (restart_i)  fired_o <= 1'b0;
        else if (expire_i)   fired_o <= 1'b1;
    end
endmodule

// File: rtl/wdog_steer.sv
// Watchdog top: control register, interval decode, countdown and steered
// expiry actions. Assumes tick16_en is a single-cycle enable in clk domain.
module wdog_steer
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16_en,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             cfg_rd,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             wd_irq,
    output logic             wd_rst_req,
    output logic             wd_fired,
    output logic             ctl_bit_clr
);
    wdog_cfg_t        cfg_q;
    wdog_cfg_t        cfg_next;
    logic [CNT_W-1:0] load;
    logic             restart;
    logic             expire;

    // A restart is any access; a write uses the incoming byte for its interval.
    assign restart  = cfg_wr | cfg_rd;
    assign cfg_next = cfg_wr ? wdog_cfg_t'(cfg_wdata) : cfg_q;
    assign cfg_rdata = cfg_q;

    wdog_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .wdata_i (wdog_cfg_t'(cfg_wdata)),
        .wipe_i  (expire & cfg_q.steer),
        .cfg_o   (cfg_q)
    );

    wdog_interval u_ivl (
        .cfg_i  (cfg_next),
        .load_o (load)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .load_i    (load),
        .tick_i    (tick16_en),
        .expire_o  (expire)
    );

    wdog_action u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .expire_i  (expire),
        .steer_i   (cfg_q.steer),
        .irq_o     (wd_irq),
        .rst_req_o (wd_rst_req),
        .clr_o     (ctl_bit_clr),
        .fired_o   (wd_fired)
    );
endmodule

// File: rtl/wdog_steer_chk.sv
// Port-level properties of the watchdog, bound onto every wdog_steer.
module wdog_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       cfg_rd,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       wd_irq,
    input logic       wd_rst_req,
    input logic       wd_fired,
    input logic       ctl_bit_clr
);
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |=> !wd_irq);
    a_r8_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |=> !wd_rst_req);
    a_r8_clr_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> ctl_bit_clr);
    a_r8_no_irq_on_rst: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> !wd_irq);
    a_r8_byte_wiped: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> (cfg_rdata == 8'h00));
    a_r6_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_irq || wd_rst_req) |-> wd_fired);
    a_r4_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));
    a_r5_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && !cfg_wr) |=> $stable(cfg_rdata));
    a_r10_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr || cfg_rd) |=> (!wd_fired && !wd_irq && !wd_rst_req));
endmodule

bind wdog_steer wdog_steer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_rd      (cfg_rd),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .wd_irq      (wd_irq),
    .wd_rst_req  (wd_rst_req),
    .wd_fired    (wd_fired),
    .ctl_bit_clr (ctl_bit_clr)
);

// File: tb/wdog_steer_test.sv
// Scoreboard bench: the driver queues each expected pulse before the tick
// that should cause it; the monitor pops on every observed pulse.
module wdog_steer_test;
    localparam logic [2:0] EV_IRQ = 3'b001;  // {clr, rst, irq}
    localparam logic [2:0] EV_RST = 3'b110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cfg_rd = 1'b0;
    logic [7:0] cfg_rdata;
    logic       wd_irq, wd_rst_req, wd_fired, ctl_bit_clr;

    int checks = 0;
    int errors = 0;
    logic [2:0] expq[$];
    string      exp_tag[$];

    wdog_steer uut (
        .clk(clk), .rst_n(rst_n), .tick16_en(tick16_en),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd),
        .cfg_rdata(cfg_rdata), .wd_irq(wd_irq), .wd_rst_req(wd_rst_req),
        .wd_fired(wd_fired), .ctl_bit_clr(ctl_bit_clr)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk); cfg_rd = 1'b1;
        @(negedge clk); cfg_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick16_en = 1'b1;
            @(negedge clk); tick16_en = 0;
        end
    endtask

    task automatic expect_pulse(input logic [2:0] ev, input string tag);
        expq.push_back(ev);
        exp_tag.push_back(tag);
    endtask

    // Monitor: every observed pulse must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && (wd_irq || wd_rst_req || ctl_bit_clr)) begin
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected pulse actual=%b expected=none",
                         {ctl_bit_clr, wd_rst_req, wd_irq});
            end else begin
                automatic string tg = exp_tag.pop_front();
                check(tg, {ctl_bit_clr, wd_rst_req, wd_irq}, expq.pop_front());
            end
        end
    end

    // Expiry timing test for a given byte with irq steering.
    task automatic run_irq(input logic [7:0] v, input int len, input string tag);
        do_write(v);
        check({tag, " R4 stored"}, cfg_rdata, v);
        ticks(len - 1);
        check({tag, " R2 not early"}, wd_fired, 0);
        expect_pulse(EV_IRQ, {tag, " R7 irq"});
        ticks(1);
        check({tag, " R6 flag set"}, wd_fired, 1);
        check({tag, " R7 irq now"}, wd_irq, 1);
        @(negedge clk);
        check({tag, " R7 irq single"}, wd_irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", cfg_rdata, 0);
        check("R1 outputs", {ctl_bit_clr, wd_fired, wd_rst_req, wd_irq}, 0);

        // R3: zero byte stops the watchdog
        do_write(8'h00);
        ticks(20);
        check("R3 stopped flag", wd_fired, 0);
        // R3: steer bit alone, multiplier zero
        do_write(8'h80);
        ticks(20);
        check("R3 steer only", cfg_rdata, 8'h80);

        // R2/R7: M=3, R=0 -> 3 ticks
        run_irq(8'h0C, 3, "M3R0");
        // R9: one-shot
        ticks(8);
        check("R9 flag kept", wd_fired, 1);

        // R5/R6: read restarts with stored byte and clears flag
        do_read();
        check("R6 flag cleared", wd_fired, 0);
        check("R5 byte kept", cfg_rdata, 8'h0C);
        // R11: idle cycles without ticks do not advance
        repeat (50) @(negedge clk);
        ticks(2);
        check("R11 still pending", wd_fired, 0);
        expect_pulse(EV_IRQ, "R5 irq after read");
        ticks(1);
        check("R5 flag", wd_fired, 1);

        // R2: resolution shift, M=1 R=2 -> 16 ticks
        run_irq(8'h06, 16, "M1R2");
        // R2: M=5 R=1 -> 20 ticks
        run_irq(8'h15, 20, "M5R1");

        // R4: write mid-count reloads the new interval
        do_write(8'h0C);
        ticks(2);
        do_write(8'h10);            // M=4 R=0
        ticks(3);
        check("R4 reload not early", wd_fired, 0);
        expect_pulse(EV_IRQ, "R4 irq after reload");
        ticks(1);

        // R8: reset steering, M=2 R=0
        do_write(8'h88);
        ticks(1);
        check("R8 not early", wd_fired, 0);
        expect_pulse(EV_RST, "R8 reset pulse");
        ticks(1);
        check("R8 reset now", {ctl_bit_clr, wd_rst_req, wd_irq}, 3'b110);
        check("R8 byte wiped", cfg_rdata, 0);
        check("R8 flag", wd_fired, 1);
        ticks(10);
        check("R8 stays stopped", cfg_rdata, 0);

        // R10: restart and last tick in the same cycle
        do_write(8'h04);            // one tick
        @(negedge clk); cfg_rd = 1'b1; tick16_en = 1'b1;
        @(negedge clk); cfg_rd = 1'b0; tick16_en = 1'b0;
        check("R10 no expiry", wd_fired, 0);
        expect_pulse(EV_IRQ, "R10 irq after full interval");
        ticks(1);
        check("R10 flag", wd_fired, 1);

        // R2: longest interval, M=31 R=3 -> 1984 ticks
        run_irq(8'h7F, 1984, "M31R3");

        repeat (4) @(negedge clk);
        check("R9 no pending pulses", expq.size(), 0);
        summary();
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end
endmodule